// File: doc/BRIEF.md
# Two-Tap Mean Filter with Request/Acknowledge Channels

This block is a streaming smoother. A producer presents an unsigned sample on a request/acknowledge channel. The block responds with the mean of that sample and the one accepted before it, on a second request/acknowledge channel. Both channels use a four-phase, return-to-zero protocol. The design is clocked and samples the incoming handshake lines on each rising edge.

Inside, a sequencer walks through four steps for each sample:
- capture the sample;
- request a sum from an adder whose completion arrives after a fixed, parameterised number of cycles;
- load the halved sum into an output holding register and raise the output request;
- once the consumer acknowledges, keep the sample as the new "previous" value and release the producer.

A new sample is not taken until both channels have fully returned to zero.

Top module: `pairAvgFilter`

## Requirements
- R1: After reset `inAck` and `outReq` are 0 and the stored previous sample is 0, so the first result equals the first sample shifted right by one.
- R2: Each result on `outData` equals (x + y) >> 1. Here x is the accepted sample and y is the previous one. The sum is formed in DATA_W+1 bits and the shift truncates.
- R3: After each completed exchange, the accepted sample becomes the previous value used by the next result.
- R4: `outReq` rises exactly ADD_CYCLES+2 rising edges after the first edge at which `inReq` is seen high while the block is idle with `outAck` low.
- R5: `inAck` rises only after `outAck` has been seen high while `outReq` is high. Until then `inAck` stays 0.
- R6: `outReq` falls only after `inReq` has been seen low. `inAck` falls only after `outAck` has been seen low, by which point `outReq` is already 0.
- R7: `outData` does not change while `outReq` is high, and it keeps the result after the exchange ends.
- R8: Changes to `inData` after `inAck` rises affect neither the result being held nor the previous value.
- R9: While `outAck` is still high, a raised `inReq` is not accepted: `inAck` and `outReq` stay 0 until `outAck` falls.
- R10: Full-scale inputs do not overflow. For DATA_W=8, the samples 255 then 255 give 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inReq | input | 1 | Producer request, sample valid |
| inData | input | DATA_W | Unsigned sample |
| inAck | output | 1 | Acknowledge to producer |
| outReq | output | 1 | Result valid request to consumer |
| outAck | input | 1 | Consumer acknowledge |
| outData | output | DATA_W | Held mean of current and previous sample |

## Verification
The protocol assertions assume the environment follows the four-phase rules. The producer keeps `inReq` high until `inAck` rises, and the consumer only raises `outAck` in answer to `outReq`. The stimulus drives every handshake from tasks that wait for the block's own edge before answering. The only departure is deliberate: `outAck` is held high across a new request to exercise the idle guard. While that happens, `outReq` is low, which is the exact case the guard property covers.

// File: rtl/pairAvgPkg.sv
package pairAvgPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADD,
    ST_SHOW,
    ST_REL,
    ST_RET
  } seqState_t;

  typedef struct packed {
    logic loadX;
    logic addReq;
    logic loadRes;
    logic loadY;
  } ctrlStrobes_t;
endpackage

// File: rtl/pairAvgCtrl.sv
module pairAvgCtrl
  import pairAvgPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inReq,
  input  logic         outAck,
  input  logic         addAck,
  output ctrlStrobes_t strobes,
  output logic         inAck,
  output logic         outReq
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (inReq && !outAck) begin
        strobes.loadX = 1'b1;
        nextState     = ST_ADD;
      end
      ST_ADD: begin
        strobes.addReq = 1'b1;
        if (addAck) begin
          strobes.loadRes = 1'b1;
          nextState       = ST_SHOW;
        end
      end
      ST_SHOW: if (outAck) begin
        strobes.loadY = 1'b1;
        nextState     = ST_REL;
      end
      ST_REL: if (!inReq) nextState = ST_RET;
      ST_RET: if (!outAck) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign outReq = (state == ST_SHOW) || (state == ST_REL);
  assign inAck  = (state == ST_REL)  || (state == ST_RET);
endmodule

// File: rtl/pairAvgData.sv
module pairAvgData
  import pairAvgPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADD_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] inData,
  output logic              addAck,
  output logic [DATA_W-1:0] outData
);
  localparam int CNT_W = $clog2(ADD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(ADD_CYCLES);

  logic [DATA_W-1:0] xReg, yReg, resReg;
  logic [DATA_W:0]   sum;
  logic [CNT_W-1:0]  addCnt;

  assign sum = {1'b0, xReg} + {1'b0, yReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg   <= '0;
      yReg   <= '0;
      resReg <= '0;
      addCnt <= '0;
    end else begin
      if (strobes.loadX)   xReg   <= inData;
      if (strobes.loadY)   yReg   <= xReg;
      if (strobes.loadRes) resReg <= sum[DATA_W:1];
      if (!strobes.addReq)       addCnt <= '0;
      else if (addCnt != CNT_END) addCnt <= addCnt + 1'b1;
    end
  end

  assign addAck  = strobes.addReq && (addCnt == CNT_END);
  assign outData = resReg;
endmodule

// File: rtl/pairAvgFilter.sv
module pairAvgFilter
  import pairAvgPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADD_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inReq,
  input  logic [DATA_W-1:0] inData,
  output logic              inAck,
  output logic              outReq,
  input  logic              outAck,
  output logic [DATA_W-1:0] outData
);
  ctrlStrobes_t strobes;
  logic         addAck;

  pairAvgCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .inReq(inReq), .outAck(outAck),
    .addAck(addAck), .strobes(strobes), .inAck(inAck), .outReq(outReq)
  );

  pairAvgData #(.DATA_W(DATA_W), .ADD_CYCLES(ADD_CYCLES)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inData(inData),
    .addAck(addAck), .outData(outData)
  );
endmodule

// File: rtl/pairAvgChecker.sv
module pairAvgChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReq,
  input logic              inAck,
  input logic              outReq,
  input logic              outAck,
  input logic [DATA_W-1:0] outData
);
  a_r5_inack_after_outack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inAck) |-> (outReq && $past(outAck)));

  a_r6_outreq_falls_after_inreq: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outReq) |-> (!$past(inReq) && inAck));

  a_r6_inack_falls_last: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inAck) |-> (!$past(outAck) && !outReq));

  a_r7_result_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outReq && $past(outReq)) |-> $stable(outData));

  a_r9_idle_guard: assert property (@(posedge clk) disable iff (!rstN)
    (!inAck && !outReq && outAck) |=> (!outReq && !inAck));
endmodule

bind pairAvgFilter pairAvgChecker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .inReq(inReq), .inAck(inAck),
  .outReq(outReq), .outAck(outAck), .outData(outData)
);

// File: tb/pairAvgFilter_tb_top.sv
module pairAvgFilter_tb_top;
  localparam int DATA_W     = 8;
  localparam int ADD_CYCLES = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inReq = 1'b0;
  logic outAck = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic inAck, outReq;
  logic [DATA_W-1:0] outData;

  int tests = 0;
  int fails = 0;
  int prevSample = 0;

  always #2 clk = ~clk;

  pairAvgFilter #(.DATA_W(DATA_W), .ADD_CYCLES(ADD_CYCLES)) dut_i (
    .clk(clk), .rstN(rstN), .inReq(inReq), .inData(inData), .inAck(inAck),
    .outReq(outReq), .outAck(outAck), .outData(outData)
  );

  task automatic check(input string req, input int actual, input int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic runSample(input int x, input bit guardFirst);
    int expMean;
    int edges;
    expMean = (x + prevSample) / 2;
    if (guardFirst) begin
      @(negedge clk);
      outAck = 1'b1; inData = DATA_W'(x); inReq = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      check("R9 outReq held low", int'(outReq), 0);
      check("R9 inAck held low", int'(inAck), 0);
    end
    @(negedge clk);
    inData = DATA_W'(x); inReq = 1'b1; outAck = 1'b0;
    edges = 0;
    do begin
      @(posedge clk); edges++; #1;
    end while (!outReq && edges < 40);
    check("R4 latency", edges, ADD_CYCLES + 2);
    check("R2/R3 mean", int'(outData), expMean);
    check("R5 inAck before outAck", int'(inAck), 0);
    repeat (3) @(negedge clk);
    check("R7 held", int'(outData), expMean);
    check("R5 inAck still low", int'(inAck), 0);
    outAck = 1'b1;
    @(posedge clk); #1;
    check("R5 inAck rises", int'(inAck), 1);
    @(negedge clk);
    inData = ~DATA_W'(x);
    repeat (2) @(posedge clk); #1;
    check("R6 outReq held while inReq high", int'(outReq), 1);
    check("R8 result unaffected", int'(outData), expMean);
    @(negedge clk);
    inReq = 1'b0;
    @(posedge clk); #1;
    check("R6 outReq falls", int'(outReq), 0);
    check("R6 inAck held", int'(inAck), 1);
    @(negedge clk);
    outAck = 1'b0;
    @(posedge clk); #1;
    check("R6 inAck falls", int'(inAck), 0);
    check("R7 result kept", int'(outData), expMean);
    prevSample = x;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 inAck reset", int'(inAck), 0);
    check("R1 outReq reset", int'(outReq), 0);
    @(negedge clk);
    rstN = 1'b1;
    runSample(10, 1'b0);   // R1: first result uses zero previous
    runSample(20, 1'b0);   // R3
    runSample(255, 1'b0);
    runSample(255, 1'b0);  // R10
    runSample(0, 1'b0);
    runSample(7, 1'b1);    // R9
    runSample(3, 1'b0);
    runSample(200, 1'b1);
    runSample(201, 1'b0);  // R2 truncation
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule